// File: doc/BRIEF.md
# Cache Configuration Tuning Controller

This block steers the search for a low-energy setting of a configurable L1 data cache. It belongs to one core. After a start pulse it walks the tunable parameters one at a time, in a fixed order: total capacity first, then line length, then associativity. For each candidate value it applies the setting and lets the core run for a fixed tuning interval. It then pulses a request to a shared energy-calculation unit. When that unit answers with calc_done, the tune_again flag tells the controller what to do next. A 1 means the last setting lowered energy, so the next candidate of the same parameter is tried. A 0 means energy rose, so the sweep stops.

When a sweep stops, the parameter's field is put back to the last candidate that lowered energy, and the next parameter starts at its first candidate. After the associativity sweep the controller pulses done and returns to idle. The cache keeps the chosen setting until the next run. The setting is an 11-bit word made of three one-hot fields. This word drives way shutdown, way concatenation and line-length selection in the cache.

Top module: `cache_cfg_tuner`

## Requirements
- R1: While reset is held and after it is released, the configuration word is 11'h121 (2 KB, 1-way, 16 B), and calc_start_o and done_o are 0.
- R2: The configuration word holds three one-hot fields. Bits [4:0] select the capacity, where bit k means 2 KB shifted left by k. Bits [7:5] select the associativity, where bit 5+k means 2^k ways. Bits [10:8] select the line length, where bit 8+k means 16 B shifted left by k. Exactly one bit is set in each field at all times.
- R3: A start pulse in idle sets the capacity field to 2 KB on the same clock edge and leaves the other two fields unchanged.
- R4: After each edge that applies a candidate value, calc_start_o goes high for exactly one cycle. It rises on the edge INTERVAL_CYCLES clock cycles later.
- R5: A calc_done with tune_again=1, on a candidate that is not the parameter's last value, applies the next value of the same parameter on the following edge.
- R6: A calc_done with tune_again=0 restores the field to the last value in this sweep that received tune_again=1, or to the first value if none did. On the same edge it starts the next parameter at its first value.
- R7: A sweep that reaches the last value of its parameter (32 KB, 64 B or 4-way) ends there even if tune_again is 1, and keeps that value.
- R8: The parameters are swept in the order capacity, line length, associativity.
- R9: After the associativity decision, done_o is high for exactly one cycle on the decision edge. The controller then returns to idle with the configuration word held.
- R10: start_i and calc_done_i have no effect while the controller is timing an interval. calc_done_i has no effect in idle.
- R11: calc_done_i may arrive in the same cycle as calc_start_o or any number of cycles later. The configuration word stays unchanged while the controller waits for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a tuning run when the controller is idle |
| tune_again_i | input | 1 | Energy result: 1 if the last candidate lowered energy |
| calc_done_i | input | 1 | Energy result is valid this cycle |
| calc_start_o | output | 1 | Single-cycle request to the energy-calculation unit |
| done_o | output | 1 | Single-cycle pulse at the end of a tuning run |
| cfg_o | output | 11 | One-hot capacity, associativity and line-length fields |

## Verification
The bench builds the controller with a four-cycle tuning interval and the default value counts of five capacities, three line lengths and three ways. With an interval that short, every combination of sweep stopping points can be run back to back. That covers a stop at the first value, a stop at each middle value, and a run to the last value, for all three parameters. The answer latency is rotated over zero, one and two cycles. Stray start and calc_done pulses are injected during interval timing and in idle.

// File: rtl/ct_tuner_pkg.sv
package ct_tuner_pkg;

    typedef enum logic [1:0] {
        PRM_NONE  = 2'd0,
        PRM_SIZE  = 2'd1,
        PRM_LINE  = 2'd2,
        PRM_ASSOC = 2'd3
    } ct_param_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CALC = 2'd2
    } ct_state_e;

endpackage

// File: rtl/ct_interval_timer.sv
module ct_interval_timer #(
    parameter int INTERVAL_CYCLES = 500000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(INTERVAL_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(INTERVAL_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (cnt_q != LIMIT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == LIMIT);

    // R4
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LIMIT);

    // R4
    cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (cnt_q == '0));

endmodule

// File: rtl/ct_onehot_field.sv
module ct_onehot_field #(
    parameter int N_VALS = 3,
    parameter int IDX_W  = 2
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [N_VALS-1:0] onehot_o
);
    for (genvar k = 0; k < N_VALS; k++) begin : g_bit
        assign onehot_o[k] = (idx_i == IDX_W'(k));
    end
endmodule

// File: rtl/cache_cfg_tuner.sv
module cache_cfg_tuner #(
    parameter int INTERVAL_CYCLES = 500000,
    parameter int SIZE_VALS       = 5,
    parameter int ASSOC_VALS      = 3,
    parameter int LINE_VALS       = 3
) (
    input  logic                                          clk_i,
    input  logic                                          rst_ni,
    input  logic                                          start_i,
    input  logic                                          tune_again_i,
    input  logic                                          calc_done_i,
    output logic                                          calc_start_o,
    output logic                                          done_o,
    output logic [SIZE_VALS+ASSOC_VALS+LINE_VALS-1:0]     cfg_o
);
    import ct_tuner_pkg::*;

    localparam int CFG_W     = SIZE_VALS + ASSOC_VALS + LINE_VALS;
    localparam int ASSOC_LSB = SIZE_VALS;
    localparam int LINE_LSB  = SIZE_VALS + ASSOC_VALS;
    localparam int MAX_VALS  = (SIZE_VALS > ASSOC_VALS)
                             ? ((SIZE_VALS > LINE_VALS) ? SIZE_VALS : LINE_VALS)
                             : ((ASSOC_VALS > LINE_VALS) ? ASSOC_VALS : LINE_VALS);
    localparam int IDX_W     = $clog2(MAX_VALS + 1);

    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        ct_state_e state;
        ct_param_e prm;
        idx_t      cur;
        idx_t      best;
        idx_t      size_idx;
        idx_t      line_idx;
        idx_t      assoc_idx;
        logic      calc_start;
        logic      done;
    } tuner_s;

    tuner_s r_d, r_q;
    logic   tmr_restart;
    logic   tmr_expired;

    function automatic tuner_s put_field(tuner_s s, ct_param_e p, idx_t v);
        tuner_s t = s;
        case (p)
            PRM_SIZE:  t.size_idx  = v;
            PRM_LINE:  t.line_idx  = v;
            PRM_ASSOC: t.assoc_idx = v;
            default:   t = s;
        endcase
        return t;
    endfunction

    function automatic idx_t last_of(ct_param_e p);
        case (p)
            PRM_SIZE:  return idx_t'(SIZE_VALS - 1);
            PRM_LINE:  return idx_t'(LINE_VALS - 1);
            PRM_ASSOC: return idx_t'(ASSOC_VALS - 1);
            default:   return '0;
        endcase
    endfunction

    always_comb begin
        idx_t keep_idx;
        r_d            = r_q;
        r_d.calc_start = 1'b0;
        r_d.done       = 1'b0;
        tmr_restart    = 1'b0;
        keep_idx       = '0;

        case (r_q.state)
            ST_IDLE: begin
                r_d.prm  = PRM_NONE;
                r_d.cur  = '0;
                r_d.best = '0;
                if (start_i) begin
                    r_d.prm      = PRM_SIZE;
                    r_d.size_idx = '0;
                    r_d.state    = ST_WAIT;
                    tmr_restart  = 1'b1;
                end
            end

            ST_WAIT: begin
                if (tmr_expired) begin
                    r_d.calc_start = 1'b1;
                    r_d.state      = ST_CALC;
                end
            end

            ST_CALC: begin
                if (calc_done_i) begin
                    if (tune_again_i && (r_q.cur != last_of(r_q.prm))) begin
                        r_d.best    = r_q.cur;
                        r_d.cur     = r_q.cur + 1'b1;
                        r_d         = put_field(r_d, r_q.prm, r_q.cur + 1'b1);
                        r_d.state   = ST_WAIT;
                        tmr_restart = 1'b1;
                    end else begin
                        keep_idx = tune_again_i ? r_q.cur : r_q.best;
                        r_d      = put_field(r_d, r_q.prm, keep_idx);
                        r_d.cur  = '0;
                        r_d.best = '0;
                        if (r_q.prm == PRM_ASSOC) begin
                            r_d.prm   = PRM_NONE;
                            r_d.done  = 1'b1;
                            r_d.state = ST_IDLE;
                        end else begin
                            r_d.prm     = (r_q.prm == PRM_SIZE) ? PRM_LINE : PRM_ASSOC;
                            r_d         = put_field(r_d, r_d.prm, '0);
                            r_d.state   = ST_WAIT;
                            tmr_restart = 1'b1;
                        end
                    end
                end
            end

            default: begin
                r_d.state = ST_IDLE;
                r_d.prm   = PRM_NONE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{state: ST_IDLE, prm: PRM_NONE, cur: '0, best: '0,
                     size_idx: '0, line_idx: '0, assoc_idx: '0,
                     calc_start: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    ct_interval_timer #(
        .INTERVAL_CYCLES (INTERVAL_CYCLES)
    ) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (tmr_restart),
        .expired_o (tmr_expired)
    );

    ct_onehot_field #(.N_VALS(SIZE_VALS), .IDX_W(IDX_W)) u_size_enc (
        .idx_i    (r_q.size_idx),
        .onehot_o (cfg_o[SIZE_VALS-1:0])
    );

    ct_onehot_field #(.N_VALS(ASSOC_VALS), .IDX_W(IDX_W)) u_assoc_enc (
        .idx_i    (r_q.assoc_idx),
        .onehot_o (cfg_o[LINE_LSB-1:ASSOC_LSB])
    );

    ct_onehot_field #(.N_VALS(LINE_VALS), .IDX_W(IDX_W)) u_line_enc (
        .idx_i    (r_q.line_idx),
        .onehot_o (cfg_o[CFG_W-1:LINE_LSB])
    );

    assign calc_start_o = r_q.calc_start;
    assign done_o       = r_q.done;

    // R2
    field_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(cfg_o[SIZE_VALS-1:0]) == 1) &&
        ($countones(cfg_o[LINE_LSB-1:ASSOC_LSB]) == 1) &&
        ($countones(cfg_o[CFG_W-1:LINE_LSB]) == 1));

    // R4
    calc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        calc_start_o |=> !calc_start_o);

    // R4
    calc_after_interval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(calc_start_o) |-> $past(tmr_expired));

    // R9
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R9
    done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> $past(calc_done_i));

    // R10
    wait_ignores_inputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_WAIT && !tmr_expired) |=> $stable(cfg_o));

    // R11
    calc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_CALC && !calc_done_i) |=> $stable(cfg_o));

endmodule

// File: tb/cache_cfg_tuner_tb.sv
module cache_cfg_tuner_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IVL        = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tune_again = 1'b0;
    logic        calc_done = 1'b0;
    logic        calc_start;
    logic        done;
    logic [10:0] cfg;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int sz = 0, ln = 0, as_ = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_cfg_tuner #(
        .INTERVAL_CYCLES (IVL)
    ) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start),
        .tune_again_i (tune_again),
        .calc_done_i  (calc_done),
        .calc_start_o (calc_start),
        .done_o       (done),
        .cfg_o        (cfg)
    );

    function automatic logic [10:0] mk(int s, int l, int a);
        logic [10:0] w = '0;
        w[s]     = 1'b1;
        w[5 + a] = 1'b1;
        w[8 + l] = 1'b1;
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_cfg(input string req);
        logic [10:0] e = mk(sz, ln, as_);
        check(cfg == e, req, int'(cfg), int'(e));
        check(($countones(cfg[4:0]) == 1) && ($countones(cfg[7:5]) == 1) &&
              ($countones(cfg[10:8]) == 1), "R2 one-hot fields", int'(cfg), int'(e));
    endtask

    // Called at the negedge right after a candidate was applied.
    task automatic do_value(input bit t, input int d, input bit stray);
        int cycles = 0;
        logic [10:0] hold = cfg;
        if (stray) begin
            start = 1'b1;
            calc_done = 1'b1;
            tune_again = ~t;
        end
        while (!calc_start && cycles < IVL + 4) begin
            @(negedge clk);
            cycles++;
            start = 1'b0;
            calc_done = 1'b0;
            tune_again = 1'b0;
            if (!calc_start)
                check(cfg == hold, "R10 cfg unchanged during interval", int'(cfg), int'(hold));
        end
        check(cycles == IVL, "R4 interval length", cycles, IVL);
        for (int i = 0; i < d; i++) begin
            @(negedge clk);
            check(calc_start == 1'b0, "R4 calc_start single cycle", int'(calc_start), 0);
            check(cfg == hold, "R11 cfg held while awaiting result", int'(cfg), int'(hold));
        end
        calc_done = 1'b1;
        tune_again = t;
        @(negedge clk);
        calc_done = 1'b0;
        tune_again = 1'b0;
        check(calc_start == 1'b0, "R4 calc_start low after decision", int'(calc_start), 0);
    endtask

    task automatic run(input int ks, input int kl, input int ka, input int d, input bit stray);
        int ks_arr[3];
        int nv[3];
        ks_arr[0] = ks; ks_arr[1] = kl; ks_arr[2] = ka;
        nv[0] = 5; nv[1] = 3; nv[2] = 3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        sz = 0;
        check_cfg("R3 start applies 2 KB");
        for (int p = 0; p < 3; p++) begin
            int best = 0;
            for (int v = 0; v < nv[p]; v++) begin
                bit t = (v < ks_arr[p]);
                if (p == 0) sz = v; else if (p == 1) ln = v; else as_ = v;
                if (v > 0) check_cfg("R5 next value applied");
                else if (p > 0) check_cfg("R8 next parameter starts at first value");
                do_value(t, d, stray && (v == 0));
                if (!t) begin
                    if (p == 0) sz = best; else if (p == 1) ln = best; else as_ = best;
                    if (p == 2) check_cfg("R6 restore on energy rise");
                    break;
                end
                best = v;
                if (v == nv[p] - 1) begin
                    if (p == 2) check_cfg("R7 last value kept");
                    break;
                end
            end
            if (p < 2 && ks_arr[p] >= nv[p]) begin
                // next parameter's first check covers the kept last value (R7)
                if (p == 0) check(cfg[4] == 1'b1, "R7 capacity sweep ends at 32 KB", int'(cfg), 16);
            end
        end
        check(done == 1'b1, "R9 done pulse", int'(done), 1);
        @(negedge clk);
        check(done == 1'b0, "R9 done single cycle", int'(done), 0);
        check_cfg("R9 cfg held in idle");
        calc_done = 1'b1;
        tune_again = 1'b1;
        @(negedge clk);
        @(negedge clk);
        calc_done = 1'b0;
        tune_again = 1'b0;
        check_cfg("R10 calc_done ignored in idle");
        check(calc_start == 1'b0, "R10 no request in idle", int'(calc_start), 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int r = 0;
        @(negedge clk);
        @(negedge clk);
        check(cfg == 11'h121, "R1 reset configuration", int'(cfg), 'h121);
        check(calc_start == 1'b0 && done == 1'b0, "R1 reset outputs", int'({calc_start, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg == 11'h121, "R1 configuration after reset release", int'(cfg), 'h121);
        check_cfg("R2 reset fields");
        for (int ks = 0; ks <= 5; ks++) begin
            for (int kl = 0; kl <= 3; kl++) begin
                for (int ka = 0; ka <= 3; ka++) begin
                    run(ks, kl, ka, r % 3, (r % 4) == 1);
                    r++;
                end
            end
        end
        summary();
    end

endmodule